// File: doc/BRIEF.md
# Split-Write Colour Palette Table

This block holds a 256-entry colour palette and lets a host load it through a byte-wide window of 512 addresses. Each entry takes two addresses. The byte at the even address supplies the red and green components as two 4-bit nibbles. The byte at the odd address supplies the blue nibble. Each 4-bit component is widened to 8 bits by placing it in the upper nibble, with a zero low nibble.

Red and green wait in a staging register. The entry becomes visible only when its odd byte arrives, and all three components change together at that point. A separate lookup port takes an 8-bit pixel index and returns the 24-bit colour one clock later. The window stays shut after reset until an init strobe opens it.

A small state machine controls the write side. Its states are:

- `ST_LOCKED`: the window is shut.
- `ST_EMPTY`: the window is open and nothing has been staged since it opened.
- `ST_HELD`: red and green are staged.

Its transitions are:

- **open**: `ST_LOCKED` to `ST_EMPTY`, on `init_stb`.
- **stage**: `ST_EMPTY` or `ST_HELD` to `ST_HELD`, on an even write.
- **commit**: `ST_EMPTY` or `ST_HELD` to `ST_EMPTY`, on an odd write.

Top module: `palette_lut_writer`

## Requirements
- R1: A write to window address A targets entry A >> 1, so entry k uses addresses 2k (even) and 2k+1 (odd).
- R2: An even write stages red as {data[7:4], 4'h0}. Red appears in bits [23:16] of the colour.
- R3: An even write stages green as {data[3:0], 4'h0}. Green appears in bits [15:8] of the colour.
- R4: An odd write sets blue to {data[3:0], 4'h0}, in bits [7:0]. data[7:4] of an odd write is ignored.
- R5: An entry changes only on an odd write. An even write alone leaves every visible entry unchanged.
- R6: Reset sets all 256 entries, the lookup output and the staging register to zero.
- R7: An odd write commits whatever red and green are currently staged. If the last even write was to another entry, its values are used. If nothing has been staged since reset, zero is used.
- R8: `rd_rgb` shows the entry selected by `rd_idx` one clock after it is presented. When a commit and a lookup target the same entry in the same cycle, the lookup returns the old value.
- R9: Before the first `init_stb` after reset, writes are ignored: no entry changes and nothing is staged. After `init_stb` the window stays open until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_stb | input | 1 | Opens the write window |
| wr_en | input | 1 | Write strobe for the window |
| wr_addr | input | 9 | Window-relative byte address |
| wr_data | input | 8 | Write data byte |
| rd_idx | input | 8 | Pixel index for lookup |
| rd_rgb | output | 24 | Looked-up colour {R,G,B} |

## Verification
The bench uses the default parameters: 4-bit components and 256 entries. At this size every entry can be loaded with distinct data and read back, and the expected colour is computed arithmetically from the written bytes. The full sweep checks each entry before and after its odd byte, so the index decode and the commit timing are checked across the whole table. Directed steps cover the following cases:
- writes before init;
- an odd write with no matching even write;
- a lookup colliding with a commit to the same entry.

// File: rtl/lutw_pkg.sv
package lutw_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_EMPTY  = 2'd1,
        ST_HELD   = 2'd2
    } win_state_t;
endpackage

// File: rtl/lutw_write_ctrl.sv
module lutw_write_ctrl
    import lutw_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_stb,
    input  logic                 wr_en,
    input  logic [IDX_W:0]       wr_addr,
    input  logic [2*NIB_W-1:0]   wr_data,
    output logic                 win_open,
    output logic                 commit,
    output logic [IDX_W-1:0]     commit_idx,
    output logic [6*NIB_W-1:0]   commit_rgb,
    output logic [2*NIB_W-1:0]   stage_r,
    output logic [2*NIB_W-1:0]   stage_g
);
    localparam int COMP_W = 2 * NIB_W;

    win_state_t state_q, state_d;
    logic       is_even, is_odd;
    logic [COMP_W-1:0] blue_w;

    assign is_even = wr_en && !wr_addr[0] && (state_q != ST_LOCKED);
    assign is_odd  = wr_en &&  wr_addr[0] && (state_q != ST_LOCKED);
    assign blue_w  = {wr_data[NIB_W-1:0], {NIB_W{1'b0}}};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (init_stb) state_d = ST_EMPTY;
            ST_EMPTY:  if (is_even)  state_d = ST_HELD;
            ST_HELD:   if (is_odd)   state_d = ST_EMPTY;
            default:   state_d = ST_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // Staging register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_r <= '0;
            stage_g <= '0;
        end else if (is_even) begin
            stage_r <= {wr_data[COMP_W-1:NIB_W], {NIB_W{1'b0}}};
            stage_g <= {wr_data[NIB_W-1:0], {NIB_W{1'b0}}};
        end
    end

    // Outputs
    always_comb begin
        win_open   = (state_q != ST_LOCKED);
        commit     = is_odd;
        commit_idx = wr_addr[IDX_W:1];
        commit_rgb = {stage_r, stage_g, blue_w};
    end
endmodule

// File: rtl/lutw_store.sv
module lutw_store #(
    parameter int IDX_W = 8,
    parameter int RGB_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic [RGB_W-1:0] commit_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    logic [RGB_W-1:0] entry_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[e] <= '0;
            else if (commit && (commit_idx == IDX_W'(e)))
                entry_q[e] <= commit_rgb;
        end
    end

    // Registered lookup: reads the pre-commit value on a collision
    always_ff @(posedge clk) begin
        if (!rst_n) rd_rgb <= '0;
        else        rd_rgb <= entry_q[rd_idx];
    end
endmodule

// File: rtl/palette_lut_writer.sv
module palette_lut_writer #(
    parameter int NIB_W = 4,
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_stb,
    input  logic                 wr_en,
    input  logic [IDX_W:0]       wr_addr,
    input  logic [2*NIB_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [6*NIB_W-1:0]   rd_rgb
);
    localparam int COMP_W = 2 * NIB_W;
    localparam int RGB_W  = 3 * COMP_W;

    logic              win_open;
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [RGB_W-1:0]  commit_rgb;
    logic [COMP_W-1:0] stage_r;
    logic [COMP_W-1:0] stage_g;

    lutw_write_ctrl #(.NIB_W(NIB_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .init_stb(init_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .win_open(win_open), .commit(commit), .commit_idx(commit_idx),
        .commit_rgb(commit_rgb), .stage_r(stage_r), .stage_g(stage_g)
    );

    lutw_store #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .commit_idx(commit_idx), .commit_rgb(commit_rgb),
        .rd_idx(rd_idx), .rd_rgb(rd_rgb)
    );
endmodule

// File: rtl/palette_lut_writer_chk.sv
module palette_lut_writer_chk #(
    parameter int NIB_W = 4,
    parameter int IDX_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               init_stb,
    input logic               wr_en,
    input logic [IDX_W:0]     wr_addr,
    input logic               win_open,
    input logic               commit,
    input logic [IDX_W-1:0]   commit_idx,
    input logic [2*NIB_W-1:0] stage_r,
    input logic [2*NIB_W-1:0] stage_g,
    input logic [6*NIB_W-1:0] rd_rgb
);
    p_commit_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> commit_idx == wr_addr[IDX_W:1]);

    p_low_nibbles_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rgb[4*NIB_W+NIB_W-1:4*NIB_W] == '0) && (rd_rgb[2*NIB_W+NIB_W-1:2*NIB_W] == '0)
        && (rd_rgb[NIB_W-1:0] == '0));

    p_commit_odd_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (wr_en && wr_addr[0]));

    p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && win_open && !wr_addr[0]) |=> ($stable(stage_r) && $stable(stage_g)));

    p_locked_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |-> !commit);

    p_open_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |=> win_open);

    p_open_by_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !init_stb) |=> !win_open);
endmodule

bind palette_lut_writer palette_lut_writer_chk #(.NIB_W(NIB_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .wr_en(wr_en),
    .wr_addr(wr_addr), .win_open(win_open), .commit(commit),
    .commit_idx(commit_idx), .stage_r(stage_r), .stage_g(stage_g),
    .rd_rgb(rd_rgb)
);

// File: tb/palette_lut_writer_bench.sv
module palette_lut_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_idx = '0;
    logic [23:0] rd_rgb;

    int checks = 0;
    int failures = 0;
    logic [23:0] model [256];

    always #4 clk = ~clk;

    palette_lut_writer u_palette_lut_writer (
        .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_idx(rd_idx), .rd_rgb(rd_rgb)
    );

    function automatic logic [7:0] ev_byte(int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] od_byte(int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [23:0] colour(logic [7:0] ev, logic [7:0] od);
        return {ev[7:4], 4'h0, ev[3:0], 4'h0, od[3:0], 4'h0};
    endfunction

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] idx, input logic [23:0] exp, input string req);
        @(negedge clk);
        rd_idx = idx;
        @(negedge clk);
        checks++;
        if (rd_rgb !== exp) begin
            failures++;
            $display("FAIL %s entry %0d: actual %h expected %h", req, idx, rd_rgb, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state of output and every entry
        checks++;
        if (rd_rgb !== 24'h0) begin
            failures++;
            $display("FAIL R6 output: actual %h expected 000000", rd_rgb);
        end
        for (int i = 0; i < 256; i++) chk_rd(8'(i), 24'h0, "R6");

        // R9: writes before init are ignored
        wr(9'd10, 8'hFF);
        wr(9'd11, 8'hFF);
        chk_rd(8'd5, 24'h0, "R9");

        @(negedge clk) init_stb = 1'b1;
        @(negedge clk) init_stb = 1'b0;

        // R7/R9: the locked even write did not stage anything; the odd write commits zero staged values
        wr(9'd1, 8'hF1);
        model[0] = 24'h000010;
        chk_rd(8'd0, model[0], "R7_R9");

        // R1-R5: full sweep of the table
        for (int i = 0; i < 256; i++) begin
            wr(9'(2 * i), ev_byte(i));
            chk_rd(8'(i), model[i], "R5");
            wr(9'(2 * i + 1), od_byte(i));
            model[i] = colour(ev_byte(i), od_byte(i));
            chk_rd(8'(i), model[i], "R1_R2_R3_R4");
        end
        for (int i = 0; i < 256; i++) chk_rd(8'(i), model[i], "R1");

        // R7: an odd write alone reuses the values staged for entry 255
        wr(9'd7, 8'hAC);
        model[3] = colour(ev_byte(255), 8'hAC);
        chk_rd(8'd3, model[3], "R7");

        // R8: a same-cycle lookup and commit return the old value, then the new one
        wr(9'd20, 8'h93);
        @(negedge clk);
        rd_idx = 8'd10; wr_en = 1'b1; wr_addr = 9'd21; wr_data = 8'h06;
        @(negedge clk);
        wr_en = 1'b0;
        checks++;
        if (rd_rgb !== model[10]) begin
            failures++;
            $display("FAIL R8 collision: actual %h expected %h", rd_rgb, model[10]);
        end
        model[10] = colour(8'h93, 8'h06);
        @(negedge clk);
        checks++;
        if (rd_rgb !== model[10]) begin
            failures++;
            $display("FAIL R8 after commit: actual %h expected %h", rd_rgb, model[10]);
        end

        // R9: the window stays open without a further strobe
        wr(9'd40, 8'h12);
        wr(9'd41, 8'h03);
        chk_rd(8'd20, 24'h102030, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule